// File: doc/BRIEF.md
# Byte-Serial Counter Register Interface

This block is the host-facing register file of a single quadrature counter channel. A host reaches it over an 8-bit bus with only two addresses. The data address carries the wide values one byte per access. The control address takes command bytes on writes and returns a status byte on reads. Every wide value (the preset written by the host, and the snapshot of the count read back) is 24 bits. An internal byte pointer walks through it, least significant byte first. The pointer steps on every data access and wraps to byte 0 after the third.

A control write is decoded by its top three bits. Group 000 holds the action commands. In that group, bit 0 resets the byte pointer and bit 4 copies the live count into the output latch. Bit 3 sends a one-cycle load pulse that transfers the preset into the counter. Bits 2:1 clear flags: 01 or 10 clears the borrow, carry, compare and sign flags, and 11 clears the error flag. The bits in this group can be combined in one byte, so 0x11 resets the pointer and latches the count. Groups 001, 010 and 011 load the mode register, the I/O-control register and the index-control register, taking the fields from the low five bits. Groups 100 to 111 are ignored.

The counting logic sits outside this block. It supplies the live count, one set pulse per flag and the present count direction. It uses the configuration outputs, the preset and the load pulse.

Top module: `cntr_regif`

## Requirements
- R1: After reset, every configuration output, the preset, the load pulse, the flags and the read data are zero, and the byte pointer is at byte 0.
- R2: A data-port write stores the byte in preset byte 0, 1, 2 in turn (byte 0 = bits 7:0), and a fourth write wraps back to byte 0.
- R3: Control byte 0x01 returns the byte pointer to byte 0 without changing the preset.
- R4: Control byte 0x11 captures the count into the output latch and resets the pointer. Later data-port reads return latch bytes 0, 1, 2 and then byte 0 again, each on the clock edge of the read, whatever the count does afterwards.
- R5: Control byte 0x08 raises preset_load for exactly the one cycle after the write edge. preset_load is never high at any other time.
- R6: Control byte 0x02 or 0x04 clears the borrow, carry, compare and sign flags and leaves the error flag. Control byte 0x06 clears only the error flag.
- R7: A control-port read returns the status byte. Its layout is borrow at bit 0, carry at bit 1, compare at bit 2, sign at bit 3, error at bit 4, direction at bit 5 (1 = up) and zero at bits 7:6. Each flag stays set after its one-cycle set pulse until it is cleared.
- R8: A control write 0b001xxxxx sets count_mode to bits 2:1 and quad_res to bits 4:3 (0 = non-quadrature, else resolution plus one).
- R9: A control write 0b010xxxxx sets ab_en to bit 0 and idx_load_en to bit 1.
- R10: A control write 0b011xxxxx sets idx_sync to bit 0 and idx_pol to bit 1.
- R11: A control write with bit 7 set has no effect. Configuration, preset_load, the flags and the byte pointer all keep their values.
- R12: A flag set pulse in the same cycle as a clear command for that flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_ctl | input | 1 | Address: 0 data port, 1 control port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered on the read edge |
| cnt_value | input | 24 | Live count from the counting logic |
| cnt_up | input | 1 | Current count direction, 1 = up |
| ev_borrow | input | 1 | Set pulse for the borrow flag |
| ev_carry | input | 1 | Set pulse for the carry flag |
| ev_compare | input | 1 | Set pulse for the compare flag |
| ev_sign | input | 1 | Set pulse for the sign flag |
| ev_error | input | 1 | Set pulse for the error flag |
| preset_q | output | 24 | Preset register |
| preset_load | output | 1 | One-cycle request to load the preset into the counter |
| count_mode | output | 2 | Count mode field |
| quad_res | output | 2 | Quadrature resolution plus one, 0 = non-quadrature |
| ab_en | output | 1 | A/B input enable |
| idx_load_en | output | 1 | Load the preset on an index event |
| idx_sync | output | 1 | Synchronous index mode |
| idx_pol | output | 1 | Index polarity |

## Verification
Preset writes are issued in runs of three and then four. They are also issued after a pointer reset that comes in mid-sequence, so byte lanes that are swapped, a pointer that fails to wrap and a pointer reset that is ignored each leave a different preset value. Latch reads are checked against a count that changes right after the capture, and they continue past the third byte, which separates a real snapshot from a live pass-through and shows whether the pointer wraps. Flags are set one at a time and all together, so a flag placed at the wrong status bit is exposed. Each clear command is applied to a mixed flag set, which exposes a clear that hits the wrong group. Ignored command bytes are given the same low bits as real commands, so they must be rejected on their prefix alone.

// File: rtl/cntr_regif_pkg.sv
package cntr_regif_pkg;
  localparam int BYTE_W = 8;
  localparam int NFLAGS = 5;

  typedef enum logic [2:0] {
    GRP_ACT  = 3'b000,
    GRP_MODE = 3'b001,
    GRP_IO   = 3'b010,
    GRP_IDX  = 3'b011
  } grp_e;

  typedef struct packed {
    logic ptr_rst;
    logic clr_grp;
    logic clr_err;
    logic xfer;
    logic latch;
    logic ld_mode;
    logic ld_io;
    logic ld_idx;
  } cmd_t;
endpackage

// File: rtl/regif_cmd_dec.sv
module regif_cmd_dec
  import cntr_regif_pkg::*;
(
  input  logic              ctl_wr,
  input  logic [BYTE_W-1:0] wdata,
  output cmd_t              cmd
);
  logic [2:0] grp;
  logic       act;

  always_comb begin
    grp         = wdata[BYTE_W-1 -: 3];
    act         = ctl_wr && (grp == GRP_ACT);
    cmd         = '0;
    cmd.ptr_rst = act && wdata[0];
    cmd.clr_grp = act && (wdata[2:1] == 2'b01 || wdata[2:1] == 2'b10);
    cmd.clr_err = act && (wdata[2:1] == 2'b11);
    cmd.xfer    = act && wdata[3];
    cmd.latch   = act && wdata[4];
    cmd.ld_mode = ctl_wr && (grp == GRP_MODE);
    cmd.ld_io   = ctl_wr && (grp == GRP_IO);
    cmd.ld_idx  = ctl_wr && (grp == GRP_IDX);
  end
endmodule

// File: rtl/regif_byteptr.sv
module regif_byteptr #(
  parameter int NBYTES = 3,
  localparam int PW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          clear,
  output logic [PW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst || clear)
      ptr <= '0;
    else if (step)
      ptr <= (ptr == PW'(NBYTES-1)) ? '0 : ptr + 1'b1;
  end

  // R2
  ptr_move_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !clear) |=> (ptr != $past(ptr)));

  // R3
  ptr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (ptr == '0));
endmodule

// File: rtl/regif_datareg.sv
module regif_datareg #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3,
  localparam int PW = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int CW = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PW-1:0]     ptr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              latch_en,
  input  logic [CW-1:0]     cnt_value,
  output logic [CW-1:0]     preset,
  output logic [BYTE_W-1:0] rbyte
);
  logic [NBYTES-1:0][BYTE_W-1:0] pre_q;
  logic [NBYTES-1:0][BYTE_W-1:0] lat_q;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        pre_q[i] <= '0;
        lat_q[i] <= '0;
      end else begin
        if (wr_en && ptr == PW'(i))
          pre_q[i] <= wdata;
        if (latch_en)
          lat_q[i] <= cnt_value[i*BYTE_W +: BYTE_W];
      end
    end
  end

  assign preset = pre_q;

  always_comb begin
    rbyte = '0;
    for (int i = 0; i < NBYTES; i++)
      if (ptr == PW'(i))
        rbyte = lat_q[i];
  end

  // R4
  latch_snap_chk: assert property (@(posedge clk) disable iff (rst)
    latch_en |=> (lat_q == $past(cnt_value)));

  // R2
  preset_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(pre_q));
endmodule

// File: rtl/regif_flags.sv
module regif_flags #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] ev,
  input  logic          clr_grp,
  input  logic          clr_err,
  output logic [NF-1:0] q
);
  logic [NF-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (clr_grp) clr_mask[NF-2:0] = '1;
    if (clr_err) clr_mask[NF-1]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else
      q <= (q & ~clr_mask) | ev;
  end

  // R12
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ev[0] |=> q[0]);

  // R6
  err_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_grp && !clr_err && q[NF-1]) |=> q[NF-1]);

  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_err && !ev[NF-1]) |=> !q[NF-1]);
endmodule

// File: rtl/cntr_regif.sv
module cntr_regif
  import cntr_regif_pkg::*;
#(
  parameter int NBYTES = 3,
  localparam int CW = BYTE_W * NBYTES,
  localparam int PW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_ctl,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [CW-1:0]     cnt_value,
  input  logic              cnt_up,
  input  logic              ev_borrow,
  input  logic              ev_carry,
  input  logic              ev_compare,
  input  logic              ev_sign,
  input  logic              ev_error,
  output logic [CW-1:0]     preset_q,
  output logic              preset_load,
  output logic [1:0]        count_mode,
  output logic [1:0]        quad_res,
  output logic              ab_en,
  output logic              idx_load_en,
  output logic              idx_sync,
  output logic              idx_pol
);
  cmd_t              cmd;
  logic [PW-1:0]     ptr;
  logic [BYTE_W-1:0] lat_byte;
  logic [NFLAGS-1:0] flg;
  logic              data_acc;
  logic [BYTE_W-1:0] status;

  assign data_acc = (bus_wr || bus_rd) && !bus_ctl;

  regif_cmd_dec u_dec (
    .ctl_wr (bus_wr && bus_ctl),
    .wdata  (bus_wdata),
    .cmd    (cmd)
  );

  regif_byteptr #(.NBYTES(NBYTES)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .step  (data_acc),
    .clear (cmd.ptr_rst),
    .ptr   (ptr)
  );

  regif_datareg #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_data (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr && !bus_ctl),
    .ptr       (ptr),
    .wdata     (bus_wdata),
    .latch_en  (cmd.latch),
    .cnt_value (cnt_value),
    .preset    (preset_q),
    .rbyte     (lat_byte)
  );

  regif_flags #(.NF(NFLAGS)) u_flags (
    .clk     (clk),
    .rst     (rst),
    .ev      ({ev_error, ev_sign, ev_compare, ev_carry, ev_borrow}),
    .clr_grp (cmd.clr_grp),
    .clr_err (cmd.clr_err),
    .q       (flg)
  );

  assign status = BYTE_W'({cnt_up, flg});

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata   <= '0;
      preset_load <= 1'b0;
      count_mode  <= '0;
      quad_res    <= '0;
      ab_en       <= 1'b0;
      idx_load_en <= 1'b0;
      idx_sync    <= 1'b0;
      idx_pol     <= 1'b0;
    end else begin
      preset_load <= cmd.xfer;
      if (bus_rd)
        bus_rdata <= bus_ctl ? status : lat_byte;
      if (cmd.ld_mode) begin
        count_mode <= bus_wdata[2:1];
        quad_res   <= bus_wdata[4:3];
      end
      if (cmd.ld_io) begin
        ab_en       <= bus_wdata[0];
        idx_load_en <= bus_wdata[1];
      end
      if (cmd.ld_idx) begin
        idx_sync <= bus_wdata[0];
        idx_pol  <= bus_wdata[1];
      end
    end
  end

  // R5
  load_origin_chk: assert property (@(posedge clk) disable iff (rst)
    preset_load |-> $past(bus_wr && bus_ctl && bus_wdata[7:5] == 3'b000 && bus_wdata[3]));

  // R11
  ignored_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_ctl && bus_wdata[7]) |=>
      ($stable(count_mode) && $stable(quad_res) && $stable(ab_en) &&
       $stable(idx_load_en) && $stable(idx_sync) && $stable(idx_pol) && !preset_load));
endmodule

// File: tb/cntr_regif_test.sv
module cntr_regif_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_ctl = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [23:0] cnt_value = '0;
  logic        cnt_up = 1'b0;
  logic        ev_borrow = 0, ev_carry = 0, ev_compare = 0, ev_sign = 0, ev_error = 0;
  logic [23:0] preset_q;
  logic        preset_load;
  logic [1:0]  count_mode, quad_res;
  logic        ab_en, idx_load_en, idx_sync, idx_pol;

  int vectors = 0;
  int errors  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  cntr_regif uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_ctl(bus_ctl),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_value(cnt_value),
    .cnt_up(cnt_up), .ev_borrow(ev_borrow), .ev_carry(ev_carry),
    .ev_compare(ev_compare), .ev_sign(ev_sign), .ev_error(ev_error),
    .preset_q(preset_q), .preset_load(preset_load), .count_mode(count_mode),
    .quad_res(quad_res), .ab_en(ab_en), .idx_load_en(idx_load_en),
    .idx_sync(idx_sync), .idx_pol(idx_pol)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic ctl, input logic [7:0] d);
    @(negedge clk);
    bus_ctl = ctl; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic ctl, input logic [7:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_ctl = ctl; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] m);
    @(negedge clk);
    {ev_error, ev_sign, ev_compare, ev_carry, ev_borrow} = m;
    @(negedge clk);
    {ev_error, ev_sign, ev_compare, ev_carry, ev_borrow} = '0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          vectors++; errors++;
          $display("FAIL read: actual 0x%0h expected none", bus_rdata);
        end else begin
          check(tag_q.pop_front(), {24'h0, bus_rdata}, {24'h0, exp_q.pop_front()});
        end
      end
    end
  end

  initial begin
    #1_000_000;
    errors++; vectors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 preset", preset_q, 0);
    check("R1 cfg", {count_mode, quad_res, ab_en, idx_load_en, idx_sync, idx_pol}, 0);
    check("R1 load", preset_load, 0);
    check("R1 rdata", bus_rdata, 0);
    rd(1, 8'h00, "R1 status");

    // R2
    wr(0, 8'h11); wr(0, 8'h22); wr(0, 8'h33);
    check("R2 three bytes", preset_q, 24'h332211);
    wr(0, 8'h44);
    check("R2 wrap", preset_q, 24'h332244);

    // R3
    wr(1, 8'h01);
    check("R3 preset kept", preset_q, 24'h332244);
    wr(0, 8'hAA);
    check("R3 pointer reset", preset_q, 24'h3322AA);

    // R5
    check("R5 idle", preset_load, 0);
    @(negedge clk);
    bus_ctl = 1; bus_wdata = 8'h08; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    check("R5 pulse", preset_load, 1);
    @(negedge clk);
    check("R5 one cycle", preset_load, 0);

    // R4 (pointer sits at byte 1 here)
    cnt_value = 24'hABCDEF;
    wr(1, 8'h11);
    cnt_value = 24'h000000;
    rd(0, 8'hEF, "R4 byte0");
    rd(0, 8'hCD, "R4 byte1");
    rd(0, 8'hAB, "R4 byte2");
    rd(0, 8'hEF, "R4 wrap");

    // R7
    pulse(5'b00001); rd(1, 8'h01, "R7 borrow");
    pulse(5'b00010); rd(1, 8'h03, "R7 carry");
    pulse(5'b00100); rd(1, 8'h07, "R7 compare");
    pulse(5'b01000); rd(1, 8'h0F, "R7 sign");
    pulse(5'b10000); rd(1, 8'h1F, "R7 error");
    cnt_up = 1'b1;
    rd(1, 8'h3F, "R7 direction");

    // R6
    wr(1, 8'h02); rd(1, 8'h30, "R6 clear 0x02");
    pulse(5'b11111);
    wr(1, 8'h06); rd(1, 8'h2F, "R6 clear error");
    wr(1, 8'h04); rd(1, 8'h20, "R6 clear 0x04");

    // R12
    @(negedge clk);
    bus_ctl = 1; bus_wdata = 8'h02; bus_wr = 1; ev_borrow = 1;
    @(negedge clk);
    bus_wr = 0; ev_borrow = 0;
    rd(1, 8'h21, "R12 set wins");

    // R8
    wr(1, 8'h3E);
    check("R8 mode 3/3", {count_mode, quad_res}, 4'b1111);
    wr(1, 8'h2A);
    check("R8 mode 1/1", {count_mode, quad_res}, 4'b0101);
    // R9
    wr(1, 8'h43); check("R9 io 11", {ab_en, idx_load_en}, 2'b11);
    wr(1, 8'h41); check("R9 io 10", {ab_en, idx_load_en}, 2'b10);
    // R10
    wr(1, 8'h62); check("R10 idx pol", {idx_sync, idx_pol}, 2'b01);
    wr(1, 8'h61); check("R10 idx sync", {idx_sync, idx_pol}, 2'b10);

    // R11
    wr(1, 8'h01);
    wr(0, 8'h55);
    wr(1, 8'hE1);
    wr(1, 8'hBE);
    wr(1, 8'hFF);
    check("R11 cfg kept", {count_mode, quad_res, ab_en, idx_load_en, idx_sync, idx_pol},
          {2'b01, 2'b01, 1'b1, 1'b0, 1'b1, 1'b0});
    check("R11 no load", preset_load, 0);
    wr(0, 8'h66);
    check("R11 pointer kept", preset_q, 24'h336655);
    rd(1, 8'h21, "R11 flags kept");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule